// File: doc/BRIEF.md
# Interrupt Front End and Stacking Sequencer

This block sits beside the instruction decoder of an 8-bit processor with a 16-bit program counter and an 8-bit stack pointer. It watches two active-low request lines, a maskable one that acts on its level and a non-maskable one that acts on its falling edge. At each instruction boundary, signalled by the decoder, it decides whether a hardware interrupt should be taken. When one is taken, it drives the memory bus itself. It writes the return address and a status byte to the stack, then reads a 16-bit handler address from a fixed vector location.

The decoder also hands the block a software break. The break runs the same stacking sequence, but it pushes a return address one byte further on and sets a marker bit in the pushed status. After reset the block fetches the reset vector and pushes nothing. At the end of every sequence it gives the decoder the new program counter, the updated stack pointer and a pulse that sets the interrupt-disable flag.

Top module: `irq_seq`

## Requirements
- R1: While reset is high, `busy` is 1 and `we` and `pc_load` are 0. After reset is released, the block reads 0xFFFC and then 0xFFFD with `vec_pull` high. It then pulses `pc_load` and `set_i` with `new_pc` = {byte at 0xFFFD, byte at 0xFFFC}. It makes no stack write and leaves `sp_load` at 0.
- R2: A sequence begins the cycle after the start condition. It writes the high byte of the return PC to 0x0100+SP, the low byte to 0x0100+SP-1 and the status byte to 0x0100+SP-2, one per cycle, with `we` high. The SP arithmetic wraps within page 0x01.
- R3: The pushed status byte is {N, V, 1, B, D, I, Z, C} from bit 7 down to bit 0. N, V, D, I, Z and C are copied from `status_in` bits 7, 6, 3, 2, 1 and 0. Bit 5 is forced to 1. B (bit 4) is 1 for a break and 0 for a hardware request, whatever `status_in` bit 4 holds.
- R4: A `brk_req` pulse while the block is idle starts a break sequence. The pushed return address is `pc_in`+1, modulo 2^16, and the vector is read from 0xFFFE/0xFFFF.
- R5: The maskable request is taken at a boundary only if `irq_n` has been low for at least three cycles and `status_in` bit 2 (I) is 0. Its vector is 0xFFFE/0xFFFF and its pushed return address is `pc_in`. When I is 1, no sequence starts.
- R6: A falling edge on `nmi_n` is latched and is taken at the next boundary even when I is 1. A line that stays low after its edge has been serviced starts no further sequence.
- R7: If a non-maskable request and a maskable request are both pending at a boundary, the non-maskable one is served first, from vector 0xFFFA/0xFFFB. The still-low maskable request is served at the following boundary.
- R8: No hardware sequence starts without an `insn_done` pulse. A latched non-maskable request waits for a boundary, and `busy` stays 0 until then.
- R9: `vec_pull` is high in exactly the two vector-read cycles and never together with `we`. In the following cycle `pc_load`, `set_i` and `sp_load` pulse for one cycle, with `new_pc` = {high vector byte, low vector byte} and `sp_out` = SP-3. `busy` is 0 in the cycle after that.
- R10: The non-maskable latch is cleared as its vector fetch begins. A falling edge that arrives during that fetch or later is kept and served at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 1 | Maskable request, active low, level |
| nmi_n | input | 1 | Non-maskable request, active low, falling edge |
| insn_done | input | 1 | Pulse: current instruction has completed |
| brk_req | input | 1 | Pulse: decoder has fetched a break opcode |
| pc_in | input | 16 | Next PC at a boundary; PC after the break opcode for a break |
| sp_in | input | 8 | Current stack pointer |
| status_in | input | 8 | Current status flags |
| rdata | input | 8 | Read data returned for `addr` in the same cycle |
| addr | output | 16 | Bus address |
| wdata | output | 8 | Write data |
| we | output | 1 | Write strobe |
| vec_pull | output | 1 | High while a vector byte is addressed |
| busy | output | 1 | Sequencer owns the bus |
| pc_load | output | 1 | Pulse: load `new_pc` into PC |
| new_pc | output | 16 | Handler address |
| sp_load | output | 1 | Pulse: load `sp_out` into SP |
| sp_out | output | 8 | Stack pointer after the pushes |
| set_i | output | 1 | Pulse: set the interrupt-disable flag |

## Verification
Several rules are checked on every cycle: writes fall only in the stack page, a vector read never coincides with a write, the status push is always followed by a vector read, the load pulse always follows a vector read, and the block is idle after a load. The latch rises only after a high-to-low step of the synchronized line. Masking, the priority between the two request kinds, and the single service of a line held low are shown only by the bench's scenarios. So are a late edge that survives its own clear, the exact bytes and addresses pushed, and the break offset with its wrap at 0xFFFF.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int SP_W   = 8;
    localparam logic [ADDR_W-SP_W-1:0] STACK_PAGE = 'h01;
    localparam logic [ADDR_W-1:0] VEC_TOP  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] VEC_NMI  = VEC_TOP - ADDR_W'(5);
    localparam logic [ADDR_W-1:0] VEC_RST  = VEC_TOP - ADDR_W'(3);
    localparam logic [ADDR_W-1:0] VEC_MASK = VEC_TOP - ADDR_W'(1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_RSTV, ST_PSH_H, ST_PSH_L, ST_PSH_P, ST_VEC_L, ST_VEC_H, ST_LOAD
    } seq_state_t;

    typedef enum logic [1:0] {SRC_RST, SRC_NMI, SRC_IRQ, SRC_BRK} src_t;

    typedef struct packed {
        src_t              src;
        logic [ADDR_W-1:0] ret_pc;
        logic [DATA_W-1:0] stat;
    } frame_t;

    function automatic logic [ADDR_W-1:0] vec_base(input src_t s);
        case (s)
            SRC_NMI: return VEC_NMI;
            SRC_RST: return VEC_RST;
            default: return VEC_MASK;
        endcase
    endfunction

    // bit 5 forced high, bit 4 marks a software break
    function automatic logic [DATA_W-1:0] pack_status(input logic [DATA_W-1:0] p,
                                                      input logic brk);
        logic [DATA_W-1:0] r;
        r    = p;
        r[5] = 1'b1;
        r[4] = brk;
        return r;
    endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES == 0) begin : g_pass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
            assign q = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic irq_s,
    input  logic nmi_s,
    input  logic nmi_clr,
    input  logic i_flag,
    input  logic boundary,
    input  logic brk_req,
    input  logic idle,
    output logic start,
    output src_t src,
    output logic nmi_pend
);
    logic nmi_prev;
    logic nmi_fall;

    assign nmi_fall = nmi_prev & ~nmi_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev <= 1'b1;
            nmi_pend <= 1'b0;
        end else begin
            nmi_prev <= nmi_s;
            nmi_pend <= nmi_fall | (nmi_pend & ~nmi_clr);
        end
    end

    always_comb begin
        start = 1'b0;
        src   = SRC_BRK;
        if (idle) begin
            if (boundary && nmi_pend) begin
                start = 1'b1;
                src   = SRC_NMI;
            end else if (boundary && !irq_s && !i_flag) begin
                start = 1'b1;
                src   = SRC_IRQ;
            end else if (brk_req) begin
                start = 1'b1;
                src   = SRC_BRK;
            end
        end
    end

    // R6: the latch only rises after a high-to-low step of the synchronized line
    p_nmi_edge_only_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_pend) |-> (!$past(nmi_s) && $past(nmi_prev)));
endmodule

// File: rtl/irq_stacker.sv
module irq_stacker
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  src_t              src,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [SP_W-1:0]   sp_in,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              we,
    output logic              vec_pull,
    output logic              busy,
    output logic              idle,
    output logic              nmi_clr,
    output logic              pc_load,
    output logic [ADDR_W-1:0] new_pc,
    output logic              sp_load,
    output logic [SP_W-1:0]   sp_out,
    output logic              set_i
);
    seq_state_t        state;
    frame_t            frm;
    logic [SP_W-1:0]   sp_r;
    logic [DATA_W-1:0] lo_r, hi_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RSTV;
            frm   <= '{src: SRC_RST, ret_pc: '0, stat: '0};
            sp_r  <= '0;
            lo_r  <= '0;
            hi_r  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state      <= ST_PSH_H;
                    frm.src    <= src;
                    frm.ret_pc <= (src == SRC_BRK) ? pc_in + ADDR_W'(1) : pc_in;
                    frm.stat   <= pack_status(status_in, src == SRC_BRK);
                    sp_r       <= sp_in;
                end
                ST_RSTV:  state <= ST_VEC_L;
                ST_PSH_H: begin sp_r <= sp_r - SP_W'(1); state <= ST_PSH_L; end
                ST_PSH_L: begin sp_r <= sp_r - SP_W'(1); state <= ST_PSH_P; end
                ST_PSH_P: begin sp_r <= sp_r - SP_W'(1); state <= ST_VEC_L; end
                ST_VEC_L: begin lo_r <= rdata; state <= ST_VEC_H; end
                ST_VEC_H: begin hi_r <= rdata; state <= ST_LOAD; end
                ST_LOAD:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        addr     = '0;
        wdata    = '0;
        we       = 1'b0;
        vec_pull = 1'b0;
        case (state)
            ST_PSH_H: begin addr = {STACK_PAGE, sp_r}; wdata = frm.ret_pc[ADDR_W-1:DATA_W]; we = 1'b1; end
            ST_PSH_L: begin addr = {STACK_PAGE, sp_r}; wdata = frm.ret_pc[DATA_W-1:0];      we = 1'b1; end
            ST_PSH_P: begin addr = {STACK_PAGE, sp_r}; wdata = frm.stat;                    we = 1'b1; end
            ST_VEC_L: begin addr = vec_base(frm.src);              vec_pull = 1'b1; end
            ST_VEC_H: begin addr = vec_base(frm.src) | ADDR_W'(1); vec_pull = 1'b1; end
            default: ;
        endcase
    end

    assign idle    = (state == ST_IDLE);
    assign busy    = !idle;
    assign nmi_clr = (state == ST_PSH_P) && (frm.src == SRC_NMI);
    assign pc_load = (state == ST_LOAD);
    assign set_i   = (state == ST_LOAD);
    assign sp_load = (state == ST_LOAD) && (frm.src != SRC_RST);
    assign new_pc  = {hi_r, lo_r};
    assign sp_out  = sp_r;

    // R2: pushes land in the stack page
    p_push_page_r2: assert property (@(posedge clk) disable iff (rst)
        we |-> addr[ADDR_W-1:SP_W] == STACK_PAGE);
    // R2: the status push is followed by the first vector read
    p_push_then_vec_r2: assert property (@(posedge clk) disable iff (rst)
        (we && state == ST_PSH_P) |=> (vec_pull && !we));
    // R9: vector reads never write
    p_vec_no_write_r9: assert property (@(posedge clk) disable iff (rst)
        vec_pull |-> !we);
    // R9: a load pulse is always preceded by a vector read
    p_load_after_vec_r9: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> $past(vec_pull));
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_n,
    input  logic              nmi_n,
    input  logic              insn_done,
    input  logic              brk_req,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [SP_W-1:0]   sp_in,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              we,
    output logic              vec_pull,
    output logic              busy,
    output logic              pc_load,
    output logic [ADDR_W-1:0] new_pc,
    output logic              sp_load,
    output logic [SP_W-1:0]   sp_out,
    output logic              set_i
);
    logic irq_s, nmi_s, nmi_clr, idle, start, nmi_pend;
    src_t src;

    irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_irq (
        .clk(clk), .rst(rst), .d(irq_n), .q(irq_s));
    irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_nmi (
        .clk(clk), .rst(rst), .d(nmi_n), .q(nmi_s));

    irq_arbiter u_arb (
        .clk(clk), .rst(rst), .irq_s(irq_s), .nmi_s(nmi_s), .nmi_clr(nmi_clr),
        .i_flag(status_in[2]), .boundary(insn_done), .brk_req(brk_req),
        .idle(idle), .start(start), .src(src), .nmi_pend(nmi_pend));

    irq_stacker u_stk (
        .clk(clk), .rst(rst), .start(start), .src(src), .pc_in(pc_in),
        .sp_in(sp_in), .status_in(status_in), .rdata(rdata), .addr(addr),
        .wdata(wdata), .we(we), .vec_pull(vec_pull), .busy(busy), .idle(idle),
        .nmi_clr(nmi_clr), .pc_load(pc_load), .new_pc(new_pc),
        .sp_load(sp_load), .sp_out(sp_out), .set_i(set_i));

    // R9: the sequencer releases the bus right after the load pulse
    p_idle_after_load_r9: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> !busy);
endmodule

// File: tb/tb_irq_seq.sv
`timescale 1ns/1ps
module tb_irq_seq;
    logic clk = 1'b0, rst = 1'b1;
    logic irq_n = 1'b1, nmi_n = 1'b1, insn_done = 1'b0, brk_req = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  sp_in = 8'hFF, status_in = 8'h00, rdata;
    logic [15:0] addr, new_pc;
    logic [7:0]  wdata, sp_out;
    logic we, vec_pull, busy, pc_load, sp_load, set_i;
    logic [7:0] v_nl = 8'h11, v_nh = 8'h22, v_rl = 8'h33, v_rh = 8'h44, v_il = 8'h55, v_ih = 8'h66;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    irq_seq dut (.*);

    always_comb begin
        case (addr)
            16'hFFFA: rdata = v_nl;  16'hFFFB: rdata = v_nh;
            16'hFFFC: rdata = v_rl;  16'hFFFD: rdata = v_rh;
            16'hFFFE: rdata = v_il;  16'hFFFF: rdata = v_ih;
            default:  rdata = 8'h00;
        endcase
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_stat(input logic [7:0] s, input bit brk);
        return {s[7:6], 1'b1, brk, s[3:0]};
    endfunction

    function automatic logic [15:0] exp_vec(input int kind); // 0 irq, 1 brk, 2 nmi
        return (kind == 2) ? 16'hFFFA : 16'hFFFE;
    endfunction

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drives one boundary or break pulse from a negedge; returns at the next negedge
    task automatic fire(input bit is_brk);
        if (is_brk) brk_req = 1'b1; else insn_done = 1'b1;
        @(negedge clk);
        brk_req = 1'b0; insn_done = 1'b0;
    endtask

    task automatic expect_none(input string req, input int n);
        logic bad = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (busy !== 1'b0 || we !== 1'b0) bad = 1'b1;
            @(negedge clk);
        end
        chk(req, {63'd0, bad}, 64'd0);
    endtask

    // checks the whole sequence; drop_at>0 pulls nmi_n low after that cycle
    task automatic run_seq(input string req, input int kind, input logic [15:0] pc,
                           input logic [7:0] sp, input logic [7:0] st, input int drop_at);
        logic [15:0] rpc = (kind == 1) ? pc + 16'd1 : pc;
        logic [15:0] vb = exp_vec(kind);
        logic [7:0] lo = (kind == 2) ? v_nl : v_il;
        logic [7:0] hi = (kind == 2) ? v_nh : v_ih;
        chk({req, " R2 push PCH"}, {we, vec_pull, addr, wdata}, {1'b1, 1'b0, 8'h01, sp, rpc[15:8]});
        if (drop_at == 1) nmi_n = 1'b0;
        @(negedge clk);
        chk({req, " R2 push PCL"}, {we, vec_pull, addr, wdata}, {1'b1, 1'b0, 8'h01, sp - 8'd1, rpc[7:0]});
        @(negedge clk);
        chk({req, " R3 push status"}, {we, addr, wdata}, {1'b1, 8'h01, sp - 8'd2, exp_stat(st, kind == 1)});
        @(negedge clk);
        chk({req, " R9 vector low"}, {we, vec_pull, addr}, {1'b0, 1'b1, vb});
        if (drop_at == 4) nmi_n = 1'b0;
        @(negedge clk);
        chk({req, " R9 vector high"}, {we, vec_pull, addr}, {1'b0, 1'b1, vb + 16'd1});
        @(negedge clk);
        chk({req, " R9 load"}, {pc_load, set_i, sp_load, vec_pull, new_pc, sp_out},
            {1'b1, 1'b1, 1'b1, 1'b0, hi, lo, sp - 8'd3});
        @(negedge clk);
        chk({req, " R9 idle"}, {busy, pc_load}, 2'b00);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20ns * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        settle(3);
        chk("R1 during reset", {busy, we, pc_load}, 3'b100);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset vector low", {we, vec_pull, addr}, {1'b0, 1'b1, 16'hFFFC});
        @(negedge clk);
        chk("R1 reset vector high", {we, vec_pull, addr}, {1'b0, 1'b1, 16'hFFFD});
        @(negedge clk);
        chk("R1 reset load", {pc_load, set_i, sp_load, new_pc}, {3'b110, v_rh, v_rl});
        @(negedge clk);
        chk("R1 idle after reset", {busy}, 1'b0);

        // R5 masked request
        irq_n = 1'b0; status_in = 8'h04; pc_in = 16'h1234; sp_in = 8'hFD;
        settle(4);
        fire(0);
        expect_none("R5 masked irq ignored", 4);
        // R5 unmasked request, R3 with status bit 4 set on input
        status_in = 8'hDB;
        fire(0);
        run_seq("R5 irq taken", 0, 16'h1234, 8'hFD, 8'hDB, 0);
        irq_n = 1'b1; status_in = 8'h04;
        settle(4);

        // R8: edge latched but no boundary
        nmi_n = 1'b0;
        expect_none("R8 no boundary no service", 8);
        pc_in = 16'h8000; sp_in = 8'h01;
        fire(0);
        run_seq("R6 nmi with I set", 2, 16'h8000, 8'h01, 8'h04, 0);
        // R6 held low
        settle(3);
        fire(0);
        expect_none("R6 held low no repeat", 4);

        // R10: new edge during the vector fetch of a serviced nmi
        nmi_n = 1'b1; settle(4);
        nmi_n = 1'b0; settle(4);
        nmi_n = 1'b1; settle(1);
        pc_in = 16'h4321; sp_in = 8'h80;
        fire(0);
        run_seq("R10 first nmi", 2, 16'h4321, 8'h80, 8'h04, 4);
        expect_none("R10 waits for boundary", 3);
        // R7: nmi and irq both pending
        irq_n = 1'b0; status_in = 8'h00; settle(4);
        pc_in = 16'h0100; sp_in = 8'h7C;
        fire(0);
        run_seq("R7 R10 nmi wins", 2, 16'h0100, 8'h7C, 8'h00, 0);
        fire(0);
        run_seq("R7 irq next", 0, 16'h0100, 8'h7C, 8'h00, 0);
        irq_n = 1'b1; settle(4);

        // R4 break, including wrap
        pc_in = 16'hABCD; sp_in = 8'hFF; status_in = 8'hC3;
        fire(1);
        run_seq("R4 brk", 1, 16'hABCD, 8'hFF, 8'hC3, 0);
        pc_in = 16'hFFFF; sp_in = 8'h02; status_in = 8'h2C;
        fire(1);
        run_seq("R4 brk wrap", 1, 16'hFFFF, 8'h02, 8'h2C, 0);

        // random mix
        for (int it = 0; it < 40; it++) begin
            int kind = $urandom_range(0, 2);
            logic [15:0] pc = 16'($urandom);
            logic [7:0] sp = 8'($urandom);
            logic [7:0] st = 8'($urandom);
            v_nl = 8'($urandom); v_nh = 8'($urandom);
            v_il = 8'($urandom); v_ih = 8'($urandom);
            pc_in = pc; sp_in = sp;
            if (kind == 0) begin
                st[2] = 1'b0; status_in = st; irq_n = 1'b0; settle(4); fire(0);
            end else if (kind == 1) begin
                status_in = st; fire(1);
            end else begin
                status_in = st; nmi_n = 1'b0; settle(4); fire(0);
            end
            run_seq(kind == 0 ? "R5 rand irq" : (kind == 1 ? "R4 rand brk" : "R6 rand nmi"),
                    kind, pc, sp, st, 0);
            irq_n = 1'b1; nmi_n = 1'b1; settle(4);
        end

        finished = 1;
        summary();
    end
endmodule